// File: doc/BRIEF.md
# Receive FIFO with Fill-Level Interrupt and Stale-Data Watchdog

This block holds bytes that a serial receiver has just assembled until the host reads them. Its usable depth is set at run time to either a small or a large capacity, and it raises an interrupt when the number of bytes held reaches a threshold. The threshold is chosen by a 2-bit code whose two bits come from two separate configuration registers. The mapping from code to threshold is not monotonic, and it scales with the selected depth.

A watchdog covers the case where a message tail is too short to reach the fill threshold. When the watchdog is enabled and the FIFO holds data, it counts receiver bit-clock ticks. If no byte is written or read for 64 ticks, it latches an interrupt request that stays set until the next FIFO access. The watchdog is a three-state machine:

- `WD_IDLE`: disabled or FIFO empty.
- `WD_COUNT`: timing the gap since the last access.
- `WD_FIRED`: the gap expired.

The transitions are as follows:

- *arm*: `WD_IDLE` to `WD_COUNT`, when enabled and data is present.
- *restart*: any state to `WD_COUNT` with the counter cleared, when an access leaves data behind.
- *expire*: `WD_COUNT` to `WD_FIRED`, on the 64th tick.
- *quiet*: any state to `WD_IDLE`, when disabled or empty.

Top module: `rx_fifo_irq`

## Requirements
- R1: With `deep_sel`=0 the FIFO accepts 8 bytes and `rx_full` rises at 8 held. With `deep_sel`=1 it accepts 16 bytes and `rx_full` rises at 16. `rx_ready` is high whenever at least one byte is held.
- R2: Bytes leave in arrival order. `rd_data` always shows the oldest held byte, and a `rd_en` pulse removes it.
- R3: A write while the FIFO is full at the selected depth is dropped and sets `overrun`. `overrun` stays set until an `err_clr` pulse.
- R4: A `rd_en` pulse while the FIFO is empty has no effect. The next written byte is the one then read.
- R5: The level code is {`lvl_hi`,`lvl_lo`}, with `lvl_hi` as the MSB. In 8-byte mode, codes 00/01/10/11 raise the fill interrupt at ≥1, ≥6, ≥4 and 8 bytes held.
- R6: In 16-byte mode, codes 00/01/10/11 raise the fill interrupt at ≥1, ≥8, ≥12 and 16 bytes held.
- R7: After reset the FIFO is empty, and `irq`, `rx_ready`, `rx_full` and `overrun` are all 0.
- R8: With `wdog_en`=1 and data held, the interrupt is raised after the 64th `bit_tick` pulse with no FIFO access, and not before.
- R9: Any accepted write or read restarts the 64-tick count and clears a latched watchdog request. The request otherwise stays latched.
- R10: With `wdog_en`=0, or with the FIFO empty, the watchdog never raises the interrupt.
- R11: `irq` is the OR of the fill-level condition and the latched watchdog request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-cycle pulse per receiver 1X bit time |
| wr_en | input | 1 | Write strobe from the deserializer |
| wr_data | input | 8 | Byte to store |
| rd_en | input | 1 | Read strobe from the host |
| rd_data | output | 8 | Oldest held byte |
| deep_sel | input | 1 | 0 selects 8-byte, 1 selects 16-byte capacity |
| lvl_hi | input | 1 | Level code MSB (first config register) |
| lvl_lo | input | 1 | Level code LSB (second config register) |
| wdog_en | input | 1 | 1 enables the watchdog |
| err_clr | input | 1 | Pulse that clears `overrun` |
| irq | output | 1 | Receiver interrupt request |
| rx_ready | output | 1 | At least one byte held |
| rx_full | output | 1 | FIFO full at the selected depth |
| overrun | output | 1 | Sticky dropped-write flag |

## Verification
The hardest situation to reach from the ports is the exact watchdog boundary. The request must stay low after 63 idle ticks and rise only on the 64th, while the fill threshold is held out of the way so that only the timer can drive `irq`. The stimulus first sets code 11 in 8-byte mode and writes a single byte. It then issues isolated `bit_tick` pulses, separated by idle cycles, and samples `irq` after the 63rd and the 64th. To show that a write restarts the count, the same countdown is repeated after a second byte is written mid-count.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    typedef enum logic [1:0] {
        WD_IDLE  = 2'd0,
        WD_COUNT = 2'd1,
        WD_FIRED = 2'd2
    } wd_state_t;
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int DEPTH_LARGE = 16,
    parameter int WIDTH       = 8,
    localparam int DEPTH_SMALL = DEPTH_LARGE / 2,
    localparam int PW          = $clog2(DEPTH_LARGE),
    localparam int CW          = $clog2(DEPTH_LARGE + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             deep_sel,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    input  logic             err_clr,
    output logic [WIDTH-1:0] rd_data,
    output logic [CW-1:0]    fill,
    output logic             full,
    output logic             overrun,
    output logic             access
);
    logic [WIDTH-1:0] mem [DEPTH_LARGE];
    logic [PW-1:0]    wr_ptr, rd_ptr;
    logic [CW-1:0]    cap;
    logic             wr_ok, rd_ok;

    // Capacity follows the depth select; the physical ring is always large.
    always_comb begin
        cap   = deep_sel ? CW'(DEPTH_LARGE) : CW'(DEPTH_SMALL);
        full  = (fill >= cap);
        wr_ok = wr_en && !full;
        rd_ok = rd_en && (fill != '0);
        access  = wr_ok || rd_ok;
        rd_data = mem[rd_ptr];
    end

    always_ff @(posedge clk) begin
        if (wr_ok) mem[wr_ptr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            fill    <= '0;
            overrun <= 1'b0;
        end else begin
            if (wr_ok) wr_ptr <= wr_ptr + 1'b1;
            if (rd_ok) rd_ptr <= rd_ptr + 1'b1;
            fill <= fill + CW'(wr_ok) - CW'(rd_ok);
            if (err_clr)                overrun <= 1'b0;
            else if (wr_en && full)     overrun <= 1'b1;
        end
    end

    AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= CW'(DEPTH_LARGE)); // R1
    AST_DROP_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en && !rd_en) |=> (fill == $past(fill))); // R3
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !err_clr) |=> overrun); // R3
    AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (fill == '0 && rd_en && !wr_en) |=> (fill == '0)); // R4
endmodule

// File: rtl/rxq_level.sv
module rxq_level #(
    parameter int DEPTH_LARGE = 16,
    localparam int DEPTH_SMALL = DEPTH_LARGE / 2,
    localparam int CW          = $clog2(DEPTH_LARGE + 1),
    localparam int S_CODE1     = (3 * DEPTH_SMALL) / 4,
    localparam int S_CODE2     = DEPTH_SMALL / 2,
    localparam int L_CODE1     = DEPTH_LARGE / 2,
    localparam int L_CODE2     = (3 * DEPTH_LARGE) / 4
) (
    input  logic          deep_sel,
    input  logic          lvl_hi,
    input  logic          lvl_lo,
    input  logic [CW-1:0] fill,
    output logic          fill_hit
);
    logic [1:0]    code;
    logic [CW-1:0] thresh;

    always_comb begin
        code = {lvl_hi, lvl_lo};
        unique case (code)
            2'b00: thresh = CW'(1);
            2'b01: thresh = deep_sel ? CW'(L_CODE1) : CW'(S_CODE1);
            2'b10: thresh = deep_sel ? CW'(L_CODE2) : CW'(S_CODE2);
            2'b11: thresh = deep_sel ? CW'(DEPTH_LARGE) : CW'(DEPTH_SMALL);
            default: thresh = CW'(1);
        endcase
        fill_hit = (fill >= thresh);
    end
endmodule

// File: rtl/rxq_watchdog.sv
module rxq_watchdog
    import rxq_pkg::*;
#(
    parameter int TICKS = 64,
    localparam int TW = $clog2(TICKS)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic bit_tick,
    input  logic access,
    input  logic empty,
    output logic fire
);
    wd_state_t     state, state_nx;
    logic [TW-1:0] ticks, ticks_nx;

    always_comb begin
        state_nx = state;
        ticks_nx = ticks;
        if (!enable || empty) begin
            state_nx = WD_IDLE;
            ticks_nx = '0;
        end else if (access) begin
            state_nx = WD_COUNT;
            ticks_nx = '0;
        end else begin
            unique case (state)
                WD_IDLE: begin
                    state_nx = WD_COUNT;
                    ticks_nx = '0;
                end
                WD_COUNT: begin
                    if (bit_tick) begin
                        if (ticks == TW'(TICKS - 1)) state_nx = WD_FIRED;
                        else                         ticks_nx = ticks + 1'b1;
                    end
                end
                WD_FIRED: state_nx = WD_FIRED;
                default:  state_nx = WD_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= WD_IDLE;
            ticks <= '0;
        end else begin
            state <= state_nx;
            ticks <= ticks_nx;
        end
    end

    always_comb begin
        fire = (state == WD_FIRED);
    end

    AST_WD_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> !empty); // R10
    AST_WD_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !fire); // R10
    AST_WD_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && enable && !access) |=> fire); // R9
    AST_WD_ACCESS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        access |=> !fire); // R9
endmodule

// File: rtl/rx_fifo_irq.sv
module rx_fifo_irq #(
    parameter int DEPTH_LARGE = 16,
    parameter int WIDTH       = 8,
    parameter int WD_TICKS    = 64,
    localparam int CW         = $clog2(DEPTH_LARGE + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_tick,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    input  logic             deep_sel,
    input  logic             lvl_hi,
    input  logic             lvl_lo,
    input  logic             wdog_en,
    input  logic             err_clr,
    output logic             irq,
    output logic             rx_ready,
    output logic             rx_full,
    output logic             overrun
);
    logic [CW-1:0] fill;
    logic          access, fill_hit, wd_fire;

    rxq_store #(.DEPTH_LARGE(DEPTH_LARGE), .WIDTH(WIDTH)) u_store (
        .clk(clk), .rst_n(rst_n), .deep_sel(deep_sel),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .err_clr(err_clr),
        .rd_data(rd_data), .fill(fill), .full(rx_full),
        .overrun(overrun), .access(access)
    );

    rxq_level #(.DEPTH_LARGE(DEPTH_LARGE)) u_level (
        .deep_sel(deep_sel), .lvl_hi(lvl_hi), .lvl_lo(lvl_lo),
        .fill(fill), .fill_hit(fill_hit)
    );

    rxq_watchdog #(.TICKS(WD_TICKS)) u_wdog (
        .clk(clk), .rst_n(rst_n), .enable(wdog_en), .bit_tick(bit_tick),
        .access(access), .empty(fill == '0), .fire(wd_fire)
    );

    always_comb begin
        rx_ready = (fill != '0);
        irq      = fill_hit || wd_fire;
    end

    AST_DEFAULT_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (!lvl_hi && !lvl_lo && rx_ready) |-> irq); // R5
    AST_FULL_IMPLIES_READY: assert property (@(posedge clk) disable iff (!rst_n)
        rx_full |-> rx_ready); // R1
    AST_WD_DRIVES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        wd_fire |-> irq); // R11
endmodule

// File: tb/rx_fifo_irq_tb.sv
module rx_fifo_irq_tb;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0, rst_n = 1'b0;
    logic bit_tick = 0, wr_en = 0, rd_en = 0, err_clr = 0;
    logic [7:0] wr_data = '0, rd_data;
    logic deep_sel = 0, lvl_hi = 0, lvl_lo = 0, wdog_en = 0;
    logic irq, rx_ready, rx_full, overrun;

    int checks = 0, errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_fifo_irq u_dut (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .wr_en(wr_en),
        .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .deep_sel(deep_sel), .lvl_hi(lvl_hi), .lvl_lo(lvl_lo),
        .wdog_en(wdog_en), .err_clr(err_clr), .irq(irq),
        .rx_ready(rx_ready), .rx_full(rx_full), .overrun(overrun)
    );

    typedef struct packed {
        logic       deep;
        logic [1:0] code;
        logic [4:0] n;
        logic       exp;
    } vec_t;

    localparam vec_t VECS [16] = '{
        '{1'b0, 2'b00, 5'd0,  1'b0}, '{1'b0, 2'b00, 5'd1,  1'b1},
        '{1'b0, 2'b01, 5'd5,  1'b0}, '{1'b0, 2'b01, 5'd6,  1'b1},
        '{1'b0, 2'b10, 5'd3,  1'b0}, '{1'b0, 2'b10, 5'd4,  1'b1},
        '{1'b0, 2'b11, 5'd7,  1'b0}, '{1'b0, 2'b11, 5'd8,  1'b1},
        '{1'b1, 2'b00, 5'd1,  1'b1}, '{1'b1, 2'b01, 5'd7,  1'b0},
        '{1'b1, 2'b01, 5'd8,  1'b1}, '{1'b1, 2'b10, 5'd11, 1'b0},
        '{1'b1, 2'b10, 5'd12, 1'b1}, '{1'b1, 2'b11, 5'd15, 1'b0},
        '{1'b1, 2'b11, 5'd16, 1'b1}, '{1'b1, 2'b10, 5'd8,  1'b0}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic push(input logic [7:0] d);
        @(negedge clk); wr_en = 1; wr_data = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic pop();
        @(negedge clk); rd_en = 1;
        @(negedge clk); rd_en = 0;
    endtask

    task automatic drain();
        for (int i = 0; i < 20; i++) if (rx_ready) pop();
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); bit_tick = 1;
            @(negedge clk); bit_tick = 0;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog timeout actual=1 expected=0");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(3);
        @(negedge clk);
        // R7 reset state
        check(!irq && !rx_ready && !rx_full && !overrun, "R7 reset",
              {irq, rx_ready, rx_full, overrun}, 0);
        rst_n = 1;
        idle(1);

        // R5 R6 level table
        foreach (VECS[k]) begin
            drain();
            deep_sel = VECS[k].deep;
            {lvl_hi, lvl_lo} = VECS[k].code;
            for (int b = 0; b < int'(VECS[k].n); b++) push(8'(b));
            idle(1);
            check(irq == VECS[k].exp, VECS[k].deep ? "R6 level" : "R5 level",
                  irq, VECS[k].exp);
        end

        // R1 depth and full flag
        drain();
        deep_sel = 0; {lvl_hi, lvl_lo} = 2'b11;
        for (int b = 0; b < 7; b++) push(8'(b));
        check(!rx_full && rx_ready, "R1 small 7", rx_full, 0);
        push(8'd7);
        check(rx_full, "R1 small full", rx_full, 1);
        // R3 overflow dropped, sticky
        push(8'hEE);
        check(overrun, "R3 overrun set", overrun, 1);
        for (int b = 0; b < 8; b++) begin
            check(rd_data == 8'(b), "R3 kept data", rd_data, b);
            pop();
        end
        check(!rx_ready, "R3 dropped byte absent", rx_ready, 0);
        check(overrun, "R3 sticky", overrun, 1);
        @(negedge clk); err_clr = 1;
        @(negedge clk); err_clr = 0;
        check(!overrun, "R3 clear", overrun, 0);

        deep_sel = 1;
        for (int b = 0; b < 15; b++) push(8'hA0 + 8'(b));
        check(!rx_full, "R1 large 15", rx_full, 0);
        push(8'hAF);
        check(rx_full && !overrun, "R1 large full", rx_full, 1);
        // R2 order
        for (int b = 0; b < 16; b++) begin
            check(rd_data == 8'hA0 + 8'(b), "R2 order", rd_data, 8'hA0 + b);
            pop();
        end

        // R4 read while empty
        pop(); pop();
        check(!rx_ready, "R4 still empty", rx_ready, 0);
        push(8'h55);
        check(rd_data == 8'h55, "R4 next byte", rd_data, 8'h55);
        pop();
        check(!rx_ready, "R4 one byte only", rx_ready, 0);

        // R8 watchdog boundary; level held out of reach
        deep_sel = 0; {lvl_hi, lvl_lo} = 2'b11; wdog_en = 1;
        push(8'h11); idle(1);
        ticks(63);
        check(!irq, "R8 before 64", irq, 0);
        ticks(1);
        check(irq, "R8 at 64", irq, 1);
        check(irq, "R11 irq from watchdog", irq, 1);
        idle(5);
        check(irq, "R9 latched", irq, 1);
        // R9 restart by write
        push(8'h22);
        check(!irq, "R9 access clears", irq, 0);
        ticks(40);
        push(8'h33);
        ticks(63);
        check(!irq, "R9 restart 63", irq, 0);
        ticks(1);
        check(irq, "R9 restart 64", irq, 1);
        pop();
        check(!irq, "R9 read clears", irq, 0);

        // R10 disabled and empty
        wdog_en = 0;
        ticks(80);
        check(!irq, "R10 disabled", irq, 0);
        wdog_en = 1;
        drain();
        ticks(80);
        check(!irq, "R10 empty", irq, 0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule